// File: doc/BRIEF.md
# Latch-up Power Protection Controller

This block guards the supply rail of one device that can fall into a latched high-current state. Each cycle it judges whether the rail is drawing too much current. It uses either a digitised current code compared against a programmable trip level, or a ready-made flag from an external analog comparator. When the condition persists for enough consecutive samples, it runs a fixed recovery sequence. First it opens the series supply switch. Next it drives a crowbar that drains the charge left on the rail. Then it waits with power removed, and finally it powers the device up again without outside help. A blanking window after every power-up masks inrush current.

For telemetry, the block exposes the current phase as a one-hot vector, a saturating count of trips, and a sticky flag showing a trip since the last status read. A guard against repeated trips stops the cycle: when more trips than a set limit fall inside one observation window, the controller parks with power off and raises a lockout flag. The lockout clears only when the enable input is dropped. The trip level should be placed between the normal draw of a few milliamps and the latched draw of more than 100 mA.

Top module: `latchup_guard`

## Requirements
- R1: After reset the phase is OFF, the supply switch and crowbar are off, and the event count, sticky flag and lockout are all zero.
- R2: With enable high and no lockout, OFF moves to POWER_UP. POWER_UP keeps the switch on for blank_len cycles (minimum 1) and ignores overcurrent, then moves to ON.
- R3: In current-code mode (use_cmp=0), a sample is one cycle with cur_vld high, and it counts as overcurrent only when cur_code is strictly greater than trip_level. In comparator mode (use_cmp=1), every cycle is a sample and cmp_trip high means overcurrent.
- R4: A trip needs persist_n consecutive overcurrent samples in ON (minimum 1). A sample below the limit restarts the run. Cycles that carry no sample neither extend nor restart it.
- R5: A trip gives OPEN for one cycle with switch and crowbar off, then CROWBAR for crowbar_len cycles with only the crowbar on, then HOLD_OFF for holdoff_len cycles, then RESTART for one cycle, then POWER_UP. The switch and crowbar are never on together.
- R6: Every trip increments the event count, which saturates at its all-ones value.
- R7: A trip sets the sticky flag, and stat_rd clears it on the next edge. A trip in the same cycle wins over the read.
- R8: A trip that brings the trip total of the current window above lock_limit sets lockout. The sequence then finishes, and RESTART goes to OFF, where the block stays until enable is low, which clears lockout.
- R9: A window opens at a trip when none is open and lasts lock_window cycles. The trip total returns to zero when it ends, so trips spaced wider than the window never lock out.
- R10: Enable low in POWER_UP or ON moves to OFF on the next edge.
- R11: phase is one-hot with bit 0 OFF, bit 1 POWER_UP, bit 2 ON, bit 3 OPEN, bit 4 CROWBAR, bit 5 HOLD_OFF, bit 6 RESTART. Any other state register value returns to OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Allow the rail to be powered |
| use_cmp | input | 1 | 1 selects the comparator flag, 0 the current code |
| cur_code | input | CUR_W | Digitised supply current |
| cur_vld | input | 1 | cur_code holds a fresh sample |
| cmp_trip | input | 1 | External comparator overcurrent flag |
| trip_level | input | CUR_W | Overcurrent limit for cur_code |
| persist_n | input | PW | Consecutive overcurrent samples needed to trip |
| blank_len | input | TW | POWER_UP blanking length in cycles |
| crowbar_len | input | TW | Crowbar on-time in cycles |
| holdoff_len | input | TW | Power-off hold-off in cycles |
| lock_window | input | TW | Trip observation window in cycles |
| lock_limit | input | LW | Trips allowed in one window |
| stat_rd | input | 1 | Status read strobe, clears the sticky flag |
| pwr_en | output | 1 | Close the series supply switch |
| crowbar_en | output | 1 | Enable the rail crowbar |
| phase | output | 7 | One-hot controller phase |
| evt_count | output | EVT_W | Saturating trip count |
| tripped | output | 1 | Trip seen since the last status read |
| lockout | output | 1 | Repeated trips, parked in OFF |

## Verification
Every output is driven from a register, so each result is due on the first rising edge after the inputs that cause it. A trip appears on the edge that takes the final persisting sample. Each timed phase then holds for exactly its programmed number of edges. The driver sets inputs at a falling edge and queues, for that same cycle, the phase, switch, crowbar, count, sticky and lockout values due after the next rising edge. The monitor takes one entry 1 ns after each rising edge, which keeps expectation and sample aligned across the whole trip sequence.

// File: rtl/latchup_guard.sv
module latchup_guard #(
  parameter int CUR_W = 12,
  parameter int TW    = 16,
  parameter int PW    = 8,
  parameter int EVT_W = 8,
  parameter int LW    = 4
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             use_cmp,
  input  logic [CUR_W-1:0] cur_code,
  input  logic             cur_vld,
  input  logic             cmp_trip,
  input  logic [CUR_W-1:0] trip_level,
  input  logic [PW-1:0]    persist_n,
  input  logic [TW-1:0]    blank_len,
  input  logic [TW-1:0]    crowbar_len,
  input  logic [TW-1:0]    holdoff_len,
  input  logic [TW-1:0]    lock_window,
  input  logic [LW-1:0]    lock_limit,
  input  logic             stat_rd,
  output logic             pwr_en,
  output logic             crowbar_en,
  output logic [6:0]       phase,
  output logic [EVT_W-1:0] evt_count,
  output logic             tripped,
  output logic             lockout
);

  localparam logic [6:0] S_OFF  = 7'b0000001;
  localparam logic [6:0] S_PUP  = 7'b0000010;
  localparam logic [6:0] S_ON   = 7'b0000100;
  localparam logic [6:0] S_OPEN = 7'b0001000;
  localparam logic [6:0] S_CROW = 7'b0010000;
  localparam logic [6:0] S_HOLD = 7'b0100000;
  localparam logic [6:0] S_RST  = 7'b1000000;
  localparam logic [EVT_W-1:0] EVT_MAX = '1;
  localparam logic [LW-1:0]    TCNT_MAX = '1;
  localparam logic [PW-1:0]    PCNT_MAX = '1;
  localparam logic [TW-1:0]    ONE_T = TW'(1);
  localparam logic [PW-1:0]    ONE_P = PW'(1);

  logic [6:0]       state, state_nx;
  logic [TW-1:0]    tmr, lim, lim_eff, wcnt, win_eff;
  logic [TW:0]      tmr_inc, win_inc;
  logic [PW-1:0]    pcnt, goal;
  logic [PW:0]      pc_inc;
  logic [LW-1:0]    tcnt, tcnt_base, tcnt_nx;
  logic [EVT_W-1:0] evt_q;
  logic             sticky_q, lock_q;
  logic             timed, tmr_done, sample_vld, over, in_on, trip, win_act, win_end;

  assign sample_vld = use_cmp ? 1'b1 : cur_vld;
  assign over       = use_cmp ? cmp_trip : (cur_code > trip_level);
  assign in_on      = (state == S_ON);
  assign goal       = (persist_n == '0) ? ONE_P : persist_n;
  assign pc_inc     = {1'b0, pcnt} + (PW+1)'(1);
  assign trip       = in_on && en && sample_vld && over && (pc_inc >= {1'b0, goal});

  always_comb begin
    case (state)
      S_PUP:   lim = blank_len;
      S_CROW:  lim = crowbar_len;
      S_HOLD:  lim = holdoff_len;
      default: lim = '0;
    endcase
  end

  assign lim_eff  = (lim == '0) ? ONE_T : lim;
  assign timed    = state[1] | state[4] | state[5];
  assign tmr_inc  = {1'b0, tmr} + (TW+1)'(1);
  assign tmr_done = tmr_inc >= {1'b0, lim_eff};

  always_comb begin
    state_nx = state;
    case (state)
      S_OFF:   if (en && !lock_q) state_nx = S_PUP;
      S_PUP:   if (!en) state_nx = S_OFF; else if (tmr_done) state_nx = S_ON;
      S_ON:    if (!en) state_nx = S_OFF; else if (trip) state_nx = S_OPEN;
      S_OPEN:  state_nx = S_CROW;
      S_CROW:  if (tmr_done) state_nx = S_HOLD;
      S_HOLD:  if (tmr_done) state_nx = S_RST;
      S_RST:   state_nx = (lock_q || !en) ? S_OFF : S_PUP;
      default: state_nx = S_OFF;
    endcase
  end

  assign win_eff   = (lock_window == '0) ? ONE_T : lock_window;
  assign win_act   = (tcnt != '0);
  assign win_inc   = {1'b0, wcnt} + (TW+1)'(1);
  assign win_end   = win_act && (win_inc >= {1'b0, win_eff});
  assign tcnt_base = win_end ? '0 : tcnt;
  assign tcnt_nx   = !trip ? tcnt_base :
                     (tcnt_base == TCNT_MAX) ? TCNT_MAX : tcnt_base + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_OFF;
      tmr      <= '0;
      pcnt     <= '0;
      tcnt     <= '0;
      wcnt     <= '0;
      evt_q    <= '0;
      sticky_q <= 1'b0;
      lock_q   <= 1'b0;
    end else begin
      state <= state_nx;

      if (state_nx != state) tmr <= '0;
      else if (timed)        tmr <= tmr_inc[TW-1:0];

      if (!in_on)          pcnt <= '0;
      else if (sample_vld) pcnt <= !over ? '0 : (pcnt == PCNT_MAX) ? pcnt : pc_inc[PW-1:0];

      tcnt <= tcnt_nx;
      if (win_end || !win_act) wcnt <= '0;
      else                     wcnt <= win_inc[TW-1:0];

      if (trip && evt_q != EVT_MAX) evt_q <= evt_q + 1'b1;

      if (trip)         sticky_q <= 1'b1;
      else if (stat_rd) sticky_q <= 1'b0;

      if (trip && (tcnt_nx > lock_limit)) lock_q <= 1'b1;
      else if (state == S_OFF && !en)     lock_q <= 1'b0;
    end
  end

  assign pwr_en     = state[1] | state[2];
  assign crowbar_en = state[4];
  assign phase      = state;
  assign evt_count  = evt_q;
  assign tripped    = sticky_q;
  assign lockout    = lock_q;

  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot(phase)); // R11
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n) !(pwr_en && crowbar_en)); // R5
  AST_CROWBAR_AFTER_OPEN: assert property (@(posedge clk) disable iff (!rst_n) $rose(crowbar_en) |-> $past(state) == S_OPEN); // R5
  AST_BLANK_NO_TRIP: assert property (@(posedge clk) disable iff (!rst_n) phase[1] |=> !phase[3]); // R2
  AST_EVT_MONO: assert property (@(posedge clk) disable iff (!rst_n) evt_count >= $past(evt_count)); // R6
  AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (stat_rd && !trip) |=> !tripped); // R7
  AST_LOCK_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n) lockout |-> !pwr_en); // R8
  AST_EN_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n) (!en && (phase[1] || phase[2])) |=> phase[0]); // R10

endmodule

// File: tb/latchup_guard_tb.sv
`timescale 1ns/1ps
module latchup_guard_tb_top;

  localparam logic [6:0] P_OFF  = 7'b0000001;
  localparam logic [6:0] P_PUP  = 7'b0000010;
  localparam logic [6:0] P_ON   = 7'b0000100;
  localparam logic [6:0] P_OPEN = 7'b0001000;
  localparam logic [6:0] P_CROW = 7'b0010000;
  localparam logic [6:0] P_HOLD = 7'b0100000;
  localparam logic [6:0] P_RST  = 7'b1000000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, use_cmp = 1'b0, cur_vld = 1'b0, cmp_trip = 1'b0, stat_rd = 1'b0;
  logic [11:0] cur_code = '0;
  logic [11:0] trip_level = 12'd100;
  logic [7:0]  persist_n = 8'd3;
  logic [15:0] blank_len = 16'd4, crowbar_len = 16'd5, holdoff_len = 16'd6, lock_window = 16'd100;
  logic [3:0]  lock_limit = 4'd2;
  logic        pwr_en, crowbar_en, tripped, lockout;
  logic [6:0]  phase;
  logic [3:0]  evt_count;

  logic       mode_cmp = 1'b0;
  logic [3:0] lim_sel = 4'd2;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [6:0] ph;
    logic [3:0] ev;
    logic       stk;
    logic       lk;
    string      tag;
  } exp_t;
  exp_t q[$];
  exp_t mon_e;

  always #2.5 clk = ~clk;

  latchup_guard #(.CUR_W(12), .TW(16), .PW(8), .EVT_W(4), .LW(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .use_cmp(use_cmp), .cur_code(cur_code),
    .cur_vld(cur_vld), .cmp_trip(cmp_trip), .trip_level(trip_level),
    .persist_n(persist_n), .blank_len(blank_len), .crowbar_len(crowbar_len),
    .holdoff_len(holdoff_len), .lock_window(lock_window), .lock_limit(lock_limit),
    .stat_rd(stat_rd), .pwr_en(pwr_en), .crowbar_en(crowbar_en), .phase(phase),
    .evt_count(evt_count), .tripped(tripped), .lockout(lockout)
  );

  always @(posedge clk) begin
    #1;
    if (q.size() != 0) begin
      mon_e = q.pop_front();
      checks++;
      if (phase !== mon_e.ph || pwr_en !== (mon_e.ph[1] | mon_e.ph[2]) ||
          crowbar_en !== mon_e.ph[4] || evt_count !== mon_e.ev ||
          tripped !== mon_e.stk || lockout !== mon_e.lk) begin
        errors++;
        $display("FAIL %s: got phase=%b pwr=%b cb=%b evt=%0d stk=%b lk=%b, expected phase=%b pwr=%b cb=%b evt=%0d stk=%b lk=%b",
                 mon_e.tag, phase, pwr_en, crowbar_en, evt_count, tripped, lockout,
                 mon_e.ph, mon_e.ph[1] | mon_e.ph[2], mon_e.ph[4], mon_e.ev, mon_e.stk, mon_e.lk);
      end
    end
  end

  task automatic go(input logic e, input logic [11:0] c, input logic v, input logic m);
    @(negedge clk);
    en = e; cur_code = c; cur_vld = v; cmp_trip = m; stat_rd = 1'b0;
    use_cmp = mode_cmp; lock_limit = lim_sel;
  endtask

  task automatic cyc(input logic e, input logic [11:0] c, input logic v, input logic m,
                     input logic r, input logic [6:0] ph, input logic [3:0] ev,
                     input logic stk, input logic lk, input string tag);
    exp_t t;
    @(negedge clk);
    en = e; cur_code = c; cur_vld = v; cmp_trip = m; stat_rd = r;
    use_cmp = mode_cmp; lock_limit = lim_sel;
    t.ph = ph; t.ev = ev; t.stk = stk; t.lk = lk; t.tag = tag;
    q.push_back(t);
  endtask

  task automatic full_trip(input logic adc, input logic [3:0] ev, input logic stk0,
                           input logic lk, input logic hold, input string tag);
    logic [11:0] oc;
    oc = adc ? 12'd150 : 12'd0;
    for (int i = 0; i < 2; i++) cyc(1, oc, 1, !adc, 0, P_ON, ev - 4'd1, stk0, 0, tag);
    cyc(1, oc, 1, !adc, 0, P_OPEN, ev, 1, lk, tag);
    for (int i = 0; i < 5; i++) cyc(1, 0, 1, 0, 0, P_CROW, ev, 1, lk, "R5 crowbar");
    for (int i = 0; i < 6; i++) cyc(1, 0, 1, 0, 0, P_HOLD, ev, 1, lk, "R5 hold-off");
    cyc(1, 0, 1, 0, 0, P_RST, ev, 1, lk, "R5 restart");
    if (lk) begin
      for (int i = 0; i < 3; i++) cyc(1, 0, 1, 0, 0, P_OFF, ev, 1, 1, "R8 parked");
    end else begin
      for (int i = 0; i < 4; i++)
        cyc(1, hold ? oc : 12'd0, 1, hold && !adc, 0, P_PUP, ev, 1, 0, "R2 blanking");
      cyc(1, hold ? oc : 12'd0, 1, hold && !adc, 0, P_ON, ev, 1, 0, "R2 to ON");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0, 0, P_OFF, 0, 0, 0, "R1/R11 reset");
    cyc(0, 0, 0, 0, 0, P_OFF, 0, 0, 0, "R1 reset");
    for (int i = 0; i < 4; i++) cyc(1, 0, 1, 0, 0, P_PUP, 0, 0, 0, "R2 power-up");
    for (int i = 0; i < 3; i++) cyc(1, 0, 1, 0, 0, P_ON, 0, 0, 0, "R2 on");
    cyc(1, 12'd101, 1, 0, 0, P_ON, 0, 0, 0, "R3 above");
    cyc(1, 12'd100, 1, 0, 0, P_ON, 0, 0, 0, "R3 equal not over");
    cyc(1, 12'd150, 1, 0, 0, P_ON, 0, 0, 0, "R4 run 1");
    cyc(1, 12'd150, 0, 0, 0, P_ON, 0, 0, 0, "R4 no sample");
    cyc(1, 12'd150, 1, 0, 0, P_ON, 0, 0, 0, "R4 run 2");
    cyc(1, 12'd20,  1, 0, 0, P_ON, 0, 0, 0, "R4 restart");
    cyc(1, 12'd150, 1, 0, 0, P_ON, 0, 0, 0, "R4 run 1b");
    cyc(1, 12'd150, 1, 0, 0, P_ON, 0, 0, 0, "R4 run 2b");
    cyc(1, 12'd0,   1, 0, 0, P_ON, 0, 0, 0, "R4 below");
    full_trip(1, 4'd1, 0, 0, 0, "R5 R6 R7 current trip");
    cyc(1, 0, 1, 0, 1, P_ON, 1, 0, 0, "R7 read clears");
    cyc(1, 0, 1, 0, 0, P_ON, 1, 0, 0, "R7 stays clear");
    mode_cmp = 1'b1;
    cyc(1, 0, 1, 1, 0, P_ON, 1, 0, 0, "R3 comparator run 1");
    cyc(1, 0, 1, 1, 0, P_ON, 1, 0, 0, "R3 comparator run 2");
    cyc(1, 0, 1, 0, 0, P_ON, 1, 0, 0, "R4 comparator restart");
    full_trip(0, 4'd2, 0, 0, 1, "R3 comparator trip");
    full_trip(0, 4'd3, 1, 1, 0, "R8 third trip in window");
    cyc(0, 0, 1, 0, 0, P_OFF, 3, 1, 0, "R8 enable low clears lockout");
    for (int i = 0; i < 120; i++) go(0, 0, 1, 0);
    for (int i = 0; i < 4; i++) cyc(1, 0, 1, 0, 0, P_PUP, 3, 1, 0, "R2 re-enable");
    cyc(1, 0, 1, 0, 0, P_ON, 3, 1, 0, "R2 re-enable on");
    for (int k = 0; k < 3; k++) begin
      full_trip(0, 4'(4 + k), 1, 0, 0, "R9 spaced trips");
      for (int i = 0; i < 100; i++) go(1, 0, 1, 0);
    end
    lim_sel = 4'd15;
    for (int i = 0; i < 400; i++) go(1, 0, 1, 1);
    for (int i = 0; i < 30; i++) go(1, 0, 1, 0);
    cyc(1, 0, 1, 0, 0, P_ON, 4'd15, 1, 0, "R6 saturated");
    cyc(0, 0, 1, 0, 0, P_OFF, 4'd15, 1, 0, "R10 disable from ON");
    cyc(1, 0, 1, 0, 0, P_PUP, 4'd15, 1, 0, "R10 power-up");
    cyc(0, 0, 1, 0, 0, P_OFF, 4'd15, 1, 0, "R10 disable from POWER_UP");
    repeat (3) @(posedge clk);
    #2;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule